// File: doc/BRIEF.md
# Dual-Polynomial Reseedable Pattern Register

This block is a linear-feedback shift register that carries two feedback networks and one shared set of flip-flops. A phase select picks which network closes the loop. With the select low, the full-width register runs a sparse primitive polynomial and supplies pseudo-random stimulus. With the select high, only a shorter low section of the register is active. That section runs a second polynomial whose degree equals the largest count of care bits in any stored deterministic pattern. The stages above that section keep their values.

Deterministic seeds come from an on-chip seed store and arrive one bit per clock on a serial input. While a seed is loading, feedback is off and the active section acts as a plain shift register. After a seed is loaded, the register may run for up to a few hundred steps, so that one seed expands into several deterministic patterns. The parallel state output feeds the scan stimulus logic. Seed computation and polynomial choice happen elsewhere, and both polynomials are parameters of this block.

Top module: `lfsr_dual_core`

## Requirements
- R1: A synchronous active-high reset loads the nonzero parameter value RST_SEED (default 24'h5A3C96) into the whole register.
- R2: With phase_sel = 0 and stepping, the register shifts toward higher indices and the new bit 0 is the XOR of the stages selected by TAPS_RAND. The default mask 24'hE10000 selects stages 23, 22, 21 and 16.
- R3: With phase_sel = 1 and stepping, only stages DET_LEN-1..0 shift. Their new bit 0 is the XOR of the stages selected by TAPS_DET. The default mask 16'hD008 selects stages 15, 14, 12 and 3.
- R4: While phase_sel = 1, stages WIDTH-1..DET_LEN stay unchanged in every cycle, whatever the other inputs do.
- R5: While seed_load = 1, the active section shifts up by one stage and seed_bit enters stage 0 with no feedback. The active section is the whole register when phase_sel = 0 and the low DET_LEN stages when phase_sel = 1.
- R6: seed_load has priority over run_en. When both are high, the cycle is a seed-shift cycle.
- R7: When seed_load and run_en are both low, the whole register holds its value.
- R8: A stepping cycle never turns a nonzero active section into an all-zero one.
- R9: After DET_LEN consecutive seed-load cycles with phase_sel = 1, the low section equals the seed with its first bit at stage DET_LEN-1 and its last bit at stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_sel | input | 1 | 0: full-width pseudo-random polynomial, 1: short deterministic polynomial |
| seed_load | input | 1 | Shift one seed bit into the active section this cycle |
| seed_bit | input | 1 | Serial seed data |
| run_en | input | 1 | Advance the register by one feedback step |
| state_q | output | WIDTH | Parallel register state |

## Verification
The bench steps an arithmetic model of both polynomials alongside the register over long runs in each phase, and compares the whole state every cycle. This exposes a wrong tap, an off-by-one section boundary, or feedback taken from the wrong network. Seed loads are run in both phases with seed_load and run_en asserted together. A design that leaked feedback into a load, shifted the upper stages during deterministic loads, or let run_en win would corrupt the known seed value read back afterward. Long runs started from a single-one seed, plus mixed random traffic that switches phase mid-stream, catch designs that drift into the all-zero state or disturb the held upper stages.

// File: rtl/lfsr_dual_pkg.sv
package lfsr_dual_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SEED = 2'd1,
        ACT_STEP = 2'd2
    } lfsr_act_e;

    typedef struct packed {
        lfsr_act_e act;
        logic      short_sec;
    } lfsr_ctrl_t;

    function automatic lfsr_act_e pick_action(input logic load, input logic run);
        if (load)
            return ACT_SEED;
        else if (run)
            return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
    import lfsr_dual_pkg::*;
(
    input  logic       phase_sel,
    input  logic       seed_load,
    input  logic       run_en,
    output lfsr_ctrl_t ctrl
);
    always_comb begin
        ctrl.act       = pick_action(seed_load, run_en);
        ctrl.short_sec = phase_sel;
    end
endmodule

// File: rtl/lfsr_fb_net.sv
module lfsr_fb_net #(
    parameter int          N    = 24,
    parameter logic [N-1:0] TAPS = '1
) (
    input  logic [N-1:0] stages,
    output logic         fb
);
    logic [N:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign chain[i+1] = chain[i] ^ stages[i];
        end else begin : g_off
            assign chain[i+1] = chain[i];
        end
    end
    assign fb = chain[N];
endmodule

// File: rtl/lfsr_dual_core.sv
module lfsr_dual_core
    import lfsr_dual_pkg::*;
#(
    parameter int                 WIDTH     = 24,
    parameter int                 DET_LEN   = 16,
    parameter logic [WIDTH-1:0]   TAPS_RAND = 24'hE10000,
    parameter logic [DET_LEN-1:0] TAPS_DET  = 16'hD008,
    parameter logic [WIDTH-1:0]   RST_SEED  = 24'h5A3C96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_sel,
    input  logic             seed_load,
    input  logic             seed_bit,
    input  logic             run_en,
    output logic [WIDTH-1:0] state_q
);
    localparam int LO_MSB = DET_LEN - 1;

    lfsr_ctrl_t       ctrl;
    logic             fb_rand;
    logic             fb_det;
    logic [WIDTH-1:0] state_d;

    lfsr_ctrl u_ctrl (
        .phase_sel (phase_sel),
        .seed_load (seed_load),
        .run_en    (run_en),
        .ctrl      (ctrl)
    );

    lfsr_fb_net #(.N(WIDTH), .TAPS(TAPS_RAND)) u_fb_rand (
        .stages (state_q),
        .fb     (fb_rand)
    );

    lfsr_fb_net #(.N(DET_LEN), .TAPS(TAPS_DET)) u_fb_det (
        .stages (state_q[LO_MSB:0]),
        .fb     (fb_det)
    );

    always_comb begin
        logic in_bit;
        state_d = state_q;
        in_bit  = (ctrl.act == ACT_SEED) ? seed_bit
                : (ctrl.short_sec ? fb_det : fb_rand);
        if (ctrl.act != ACT_HOLD) begin
            if (ctrl.short_sec)
                state_d[LO_MSB:0] = {state_q[LO_MSB-1:0], in_bit};
            else
                state_d = {state_q[WIDTH-2:0], in_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RST_SEED;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/lfsr_dual_chk.sv
module lfsr_dual_chk #(
    parameter int WIDTH   = 24,
    parameter int DET_LEN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_sel,
    input logic             seed_load,
    input logic             seed_bit,
    input logic             run_en,
    input logic [WIDTH-1:0] state_q
);
    if (DET_LEN < WIDTH) begin : g_upper
        assert_upper_held_R4: assert property (@(posedge clk) disable iff (rst)
            phase_sel |=> $stable(state_q[WIDTH-1:DET_LEN]));
    end

    assert_seed_wins_R6: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> state_q[0] == $past(seed_bit));

    assert_full_seed_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (seed_load && !phase_sel) |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));

    assert_short_seed_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (seed_load && phase_sel) |=> state_q[DET_LEN-1:1] == $past(state_q[DET_LEN-2:0]));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !run_en) |=> $stable(state_q));

    assert_full_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        (run_en && !seed_load && !phase_sel && (|state_q)) |=> (|state_q));

    assert_short_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        (run_en && !seed_load && phase_sel && (|state_q[DET_LEN-1:0]))
            |=> (|state_q[DET_LEN-1:0]));
endmodule

bind lfsr_dual_core lfsr_dual_chk #(.WIDTH(WIDTH), .DET_LEN(DET_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_sel (phase_sel),
    .seed_load (seed_load),
    .seed_bit  (seed_bit),
    .run_en    (run_en),
    .state_q   (state_q)
);

// File: tb/lfsr_dual_core_tb_top.sv
module lfsr_dual_core_tb_top;
    localparam int          W    = 24;
    localparam int          L    = 16;
    localparam logic [23:0] TR   = 24'hE10000;
    localparam logic [15:0] TD   = 16'hD008;
    localparam logic [23:0] SEED = 24'h5A3C96;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_sel = 1'b0;
    logic seed_load = 1'b0;
    logic seed_bit = 1'b0;
    logic run_en = 1'b0;
    logic [W-1:0] state_q;
    logic [W-1:0] m;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lfsr_dual_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .phase_sel (phase_sel),
        .seed_load (seed_load),
        .seed_bit  (seed_bit),
        .run_en    (run_en),
        .state_q   (state_q)
    );

    function automatic logic par(input logic [W-1:0] v, input logic [W-1:0] mask);
        int ones = 0;
        for (int i = 0; i < W; i++) if (v[i] && mask[i]) ones++;
        return logic'(ones % 2);
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        n_chk++;
        if (state_q !== exp) begin
            n_bad++;
            $display("FAIL %s: state_q=%h expected=%h", req, state_q, exp);
        end
    endtask

    // Drive at negedge, model the posedge, compare at the next negedge.
    task automatic cyc(input string req, input logic ph, input logic ld,
                       input logic sb, input logic rn);
        logic nb;
        phase_sel = ph; seed_load = ld; seed_bit = sb; run_en = rn;
        if (ld || rn) begin
            if (ph) begin
                nb = ld ? sb : par({8'h00, m[L-1:0]}, {8'h00, TD});
                m[L-1:0] = {m[L-2:0], nb};
            end else begin
                nb = ld ? sb : par(m, TR);
                m = {m[W-2:0], nb};
            end
        end
        @(negedge clk);
        check(req, m);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: state_q=%h expected=completion", state_q);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] full_seed;
        logic [15:0] det_seed;
        logic        zero_seen;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m = SEED;
        check("R1", SEED);                           // R1 reset value
        for (int i = 0; i < 5; i++) cyc("R7", 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3000; i++) cyc("R2", 1'b0, 1'b0, 1'b0, 1'b1);
        full_seed = 24'hC3A517;
        for (int i = W - 1; i >= 0; i--) cyc("R5", 1'b0, 1'b1, full_seed[i], 1'b0);
        check("R5", full_seed);
        for (int i = 0; i < 2000; i++) cyc("R3", 1'b1, 1'b0, 1'b0, 1'b1);
        check("R4", {full_seed[23:16], m[15:0]});    // R4 upper held
        for (int i = 0; i < 5; i++) cyc("R7", 1'b1, 1'b0, 1'b0, 1'b0);
        det_seed = 16'hBEEF;
        for (int i = L - 1; i >= 0; i--) cyc("R6", 1'b1, 1'b1, det_seed[i], 1'b1);
        check("R9", {full_seed[23:16], det_seed});   // R9 and R6
        for (int i = 0; i < 215; i++) cyc("R3", 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = L - 1; i >= 0; i--) cyc("R9", 1'b1, 1'b1, (i == 0), 1'b0);
        check("R9", {full_seed[23:16], 16'h0001});
        zero_seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            cyc("R8", 1'b1, 1'b0, 1'b0, 1'b1);
            if (state_q[L-1:0] == '0) zero_seen = 1'b1;
        end
        n_chk++;
        if (zero_seen) begin
            n_bad++;
            $display("FAIL R8: state_q=zero expected=nonzero");
        end
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc("R5", r[0], r[1] & r[3], r[2], 1'b1);
        end
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", SEED);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule